// File: doc/BRIEF.md
# I2C Slave Read Responder

This block is the target side of an I2C bus for transfers in which the master reads. It waits for a START and collects the 7-bit address and the direction bit. When the address matches its own, it acknowledges. For a read, it then shifts out bytes that a local host places in a one-byte transmit buffer. After each byte it samples the master's acknowledge bit. An acknowledge asks for another byte. A not-acknowledge ends the transfer, and so does a STOP.

While a byte is wanted and the buffer is empty, the block holds SCL low until the host supplies one. An optional fill register can supply bytes instead, so the master can over-read without stalling. A programmable stretch limit ends any stretch that lasts too long. Clearing the enable input returns every piece of state to its reset value. Both bus lines are open-drain: the block only ever asks for a line to be pulled low, and the pads and pull-ups lie outside it.

Top module: `i2c_slave_tx`

## Requirements
- R1: Both bus inputs pass through a two-stage synchroniser. A START is SDA falling while SCL is high, and it begins address capture from any state. A STOP is SDA rising while SCL is high. A STOP returns the block to start-hunt from any state, releases both lines and empties the buffer if a read was in progress.
- R2: The first 7 bits after START, MSB first, are compared with `own_addr`. On a match the block pulls SDA low for the ninth clock. On a mismatch it drives neither line until the next START.
- R3: On a match, `rw_flag` takes the eighth address bit (1 = read). It keeps that value through every following data byte until the next matching address.
- R4: After acknowledging a read address, the block sends each byte MSB first. Each new bit appears after a falling SCL edge.
- R5: At the rising SCL edge of the ninth clock of a data byte, the block latches SDA into `ack_status` (0 = ACK, 1 = NACK) and pulses `byte_done` for one cycle. On an ACK it requests another byte. On a NACK it releases SDA at once and returns to start-hunt.
- R6: When a byte is requested, the buffer is empty and `fill_en` is low, the block holds SCL low until `host_wr` loads the buffer.
- R7: The MSB of a newly loaded byte drives SDA at least one cycle before SCL is released.
- R8: With `fill_en` high and the buffer empty, the block sends `fill_byte` with its MSB forced to 1, and holds SCL for no more than SU_CYC+2 cycles.
- R9: A `host_wr` made outside a read transfer sets `buf_full` but drives neither line. The buffer is emptied when a read transfer ends (NACK, STOP, START or timeout).
- R10: With a nonzero `stretch_limit`, a stretch that lasts `stretch_limit` cycles is ended: both lines are released, `timeout_err` is set and the block enters start-hunt. `timeout_err` clears at the next START.
- R11: While `enable` is low, all state returns to its reset value and neither line is driven. Setting `enable` high again does not bring back an earlier stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low clears all state |
| own_addr | input | 7 | Address the block answers to |
| fill_en | input | 1 | Send the fill byte when the buffer is empty |
| fill_byte | input | 8 | Fill value (MSB forced to 1 when sent) |
| stretch_limit | input | 16 | Stretch timeout in cycles; 0 disables it |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| host_wr | input | 1 | Load `host_data` into the transmit buffer |
| host_data | input | 8 | Byte to transmit |
| buf_full | output | 1 | Transmit buffer holds a byte |
| byte_done | output | 1 | One-cycle pulse when a data byte's acknowledge is sampled |
| rw_flag | output | 1 | Direction bit latched from the matching address |
| ack_status | output | 1 | Last sampled acknowledge (1 = NACK) |
| timeout_err | output | 1 | A stretch was ended by the timeout |

## Verification
A host load and the release of a stretch can fall in the same cycle. So can a host write and a transfer ending. The bench holds the master mid-clock until the block has stretched, loads the buffer, and checks that SDA already carried the MSB in the cycle before SCL was freed. It also loads the next byte while the current one is being shifted and then NACKs, and it requires the buffer to be empty afterwards. A behavioural model runs every clock beside these checks. It records acknowledge and direction values in queues and knows when the bus must be left alone, so any drive during those windows is reported.

// File: rtl/i2cs_pkg.sv
// Shared types for the I2C read responder.
// Assumes: one state encoding shared by the engine and its checker.
package i2cs_pkg;
    typedef enum logic [3:0] {
        ST_HUNT,   // waiting for START
        ST_ADDR,   // collecting address and direction
        ST_AWAIT,  // match found, wait for 8th SCL fall
        ST_AACK,   // pulling SDA low for the address acknowledge
        ST_IGN,    // not addressed, wait for next START
        ST_LOAD,   // byte wanted, stretching until one is available
        ST_SETUP,  // MSB on SDA, SCL still held
        ST_TX,     // shifting data bits out
        ST_NWAIT,  // SDA released, waiting to sample master ACK
        ST_NHOLD   // ACK seen, wait for SCL fall before next byte
    } eng_st_t;
endpackage

// File: rtl/i2cs_line_sync.sv
// Synchronises SCL and SDA and derives edge and bus-condition pulses.
// Assumes: SYNC_STAGES >= 2; the idle bus reads high.
module i2cs_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [SYNC_STAGES-1:0] scl_q, sda_q;
    logic scl_d, sda_d, scl_s;

    // Shift the pad levels through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
            scl_d <= scl_q[SYNC_STAGES-1];
            sda_d <= sda_q[SYNC_STAGES-1];
        end
    end

    assign scl_s    = scl_q[SYNC_STAGES-1];
    assign sda_s    = sda_q[SYNC_STAGES-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cs_byte_buf.sv
// One-byte transmit holding register between the host and the engine.
// Assumes: clear beats write, and write beats take in the same cycle.
module i2cs_byte_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] rdata
);
    // Track occupancy and hold the latest host byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full  <= 1'b0;
            rdata <= '0;
        end else if (clr) begin
            full  <= 1'b0;
        end else if (wr) begin
            rdata <= wdata;
            full  <= 1'b1;
        end else if (take) begin
            full  <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cs_stretch_timer.sv
// Counts cycles of an ongoing stretch and flags expiry at the limit.
// Assumes: limit of zero disables expiry; the count restarts whenever run drops.
module i2cs_stretch_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt;

    assign expired = run && (limit != '0) && (cnt >= limit);

    // Count stretch cycles, clearing when the stretch ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!expired)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_slave_tx.sv
// I2C target that answers master reads from a host-loaded byte buffer.
// Assumes: clk is much faster than SCL; lines are open-drain (outputs pull low).
module i2c_slave_tx #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int SU_CYC      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              fill_en,
    input  logic [DATA_W-1:0] fill_byte,
    input  logic [TO_W-1:0]   stretch_limit,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    output logic              buf_full,
    output logic              byte_done,
    output logic              rw_flag,
    output logic              ack_status,
    output logic              timeout_err
);
    import i2cs_pkg::*;

    localparam int MAXB  = (DATA_W > ADDR_W + 1) ? DATA_W : ADDR_W + 1;
    localparam int CNT_W = $clog2(MAXB);
    localparam int SU_W  = $clog2(SU_CYC + 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [SU_W-1:0]  SU_LAST   = SU_W'(SU_CYC - 1);
    localparam logic [DATA_W-1:0] MSB_ONE  = {1'b1, {(DATA_W-1){1'b0}}};

    eng_st_t           state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [SU_W-1:0]   su_cnt;
    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] buf_q;
    logic [DATA_W-1:0] fill_word;
    logic sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic expired, in_read, flush, take;

    i2cs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    i2cs_stretch_timer #(.TO_W(TO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state == ST_LOAD),
        .limit(stretch_limit), .expired(expired)
    );

    assign in_read = state inside {ST_LOAD, ST_SETUP, ST_TX, ST_NWAIT, ST_NHOLD};
    assign flush   = in_read && (stop_p || start_p || expired ||
                                 (state == ST_NWAIT && scl_rise && sda_s));
    assign take    = (state == ST_LOAD) && buf_full && !expired &&
                     !stop_p && !start_p;
    assign fill_word = fill_byte | MSB_ONE;

    i2cs_byte_buf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(!enable || flush),
        .wr(host_wr && enable), .wdata(host_data), .take(take),
        .full(buf_full), .rdata(buf_q)
    );

    // Engine sequencing: address phase, byte transmit, acknowledge sampling.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state       <= ST_HUNT;
            bit_cnt     <= '0;
            su_cnt      <= '0;
            addr_sh     <= '0;
            tx_sh       <= '0;
            rw_flag     <= 1'b0;
            ack_status  <= 1'b0;
            byte_done   <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (stop_p) begin
                state <= ST_HUNT;
            end else if (start_p) begin
                state       <= ST_ADDR;
                bit_cnt     <= '0;
                timeout_err <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: if (scl_rise) begin
                        if (bit_cnt == ADDR_LAST) begin
                            if (addr_sh == own_addr) begin
                                rw_flag <= sda_s;
                                state   <= ST_AWAIT;
                            end else begin
                                state   <= ST_IGN;
                            end
                        end else begin
                            addr_sh <= {addr_sh[ADDR_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_AWAIT: if (scl_fall) state <= ST_AACK;
                    ST_AACK:  if (scl_fall) state <= rw_flag ? ST_LOAD : ST_IGN;
                    ST_LOAD: begin
                        if (expired) begin
                            state       <= ST_HUNT;
                            timeout_err <= 1'b1;
                        end else if (buf_full) begin
                            tx_sh  <= buf_q;
                            su_cnt <= '0;
                            state  <= ST_SETUP;
                        end else if (fill_en) begin
                            tx_sh  <= fill_word;
                            su_cnt <= '0;
                            state  <= ST_SETUP;
                        end
                    end
                    ST_SETUP: begin
                        if (su_cnt == SU_LAST) begin
                            bit_cnt <= '0;
                            state   <= ST_TX;
                        end else begin
                            su_cnt <= su_cnt + 1'b1;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        tx_sh <= tx_sh << 1;
                        if (bit_cnt == DATA_LAST) state <= ST_NWAIT;
                        else                      bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_NWAIT: if (scl_rise) begin
                        ack_status <= sda_s;
                        byte_done  <= 1'b1;
                        state      <= sda_s ? ST_HUNT : ST_NHOLD;
                    end
                    ST_NHOLD: if (scl_fall) state <= ST_LOAD;
                    default: ;
                endcase
            end
        end
    end

    // Open-drain line requests derived from the engine state.
    assign scl_oe = (state == ST_LOAD) || (state == ST_SETUP);
    assign sda_oe = (state == ST_AACK) ||
                    (((state == ST_SETUP) || (state == ST_TX)) && !tx_sh[DATA_W-1]);
endmodule

// File: rtl/i2cs_chk.sv
// Temporal checks on the read responder, bound to its top module.
// Assumes: stop_p and start_p are the synchronised bus-condition pulses.
module i2cs_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_oe,
    input logic sda_oe,
    input logic byte_done,
    input logic ack_status,
    input logic timeout_err,
    input logic stop_p,
    input logic start_p
);
    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (!scl_oe && !sda_oe));

    // R5
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && ack_status) |-> (!scl_oe && !sda_oe));

    // R7
    msb_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_oe) && $past(enable) && !$past(stop_p) && !$past(start_p) &&
         !timeout_err) |-> $stable(sda_oe));

    // R10
    timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (!scl_oe && !sda_oe));

    // R11
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_oe && !sda_oe));
endmodule

bind i2c_slave_tx i2cs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .byte_done(byte_done), .ack_status(ack_status),
    .timeout_err(timeout_err), .stop_p(stop_p), .start_p(start_p)
);

// File: tb/test_i2c_slave_tx.sv
`timescale 1ns/1ps
module test_i2c_slave_tx;
    localparam int HALF = 24;
    localparam int SU   = 4;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
    logic [6:0]  own_addr = 7'h52;
    logic        fill_en = 1'b0;
    logic [7:0]  fill_byte = 8'hFF;
    logic [15:0] stretch_limit = '0;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic        host_wr = 1'b0;
    logic [7:0]  host_data = '0;
    logic scl_oe, sda_oe, buf_full, byte_done, rw_flag, ack_status, timeout_err;
    logic scl_bus, sda_bus;

    assign scl_bus = m_scl & ~scl_oe;
    assign sda_bus = m_sda & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_slave_tx i_i2c_slave_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .own_addr(own_addr),
        .fill_en(fill_en), .fill_byte(fill_byte), .stretch_limit(stretch_limit),
        .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .host_wr(host_wr), .host_data(host_data), .buf_full(buf_full),
        .byte_done(byte_done), .rw_flag(rw_flag), .ack_status(ack_status),
        .timeout_err(timeout_err)
    );

    int n_chk = 0, n_bad = 0;
    bit quiet_exp = 1'b0;
    bit ack_log[$];
    bit rw_log[$];
    bit prev_done = 1'b0;
    int run_len = 0, max_run = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model sampled every clock: idle windows, byte log, stretch length.
    always @(negedge clk) begin
        if (rst_n && enable && quiet_exp)
            chk(!scl_oe && !sda_oe, "R2 R9 lines left alone", {scl_oe, sda_oe}, 0);
        if (rst_n) begin
            if (prev_done && byte_done) chk(0, "R5 byte_done one cycle", 1, 0);
            if (byte_done) begin
                ack_log.push_back(ack_status);
                rw_log.push_back(rw_flag);
            end
        end
        prev_done = byte_done;
        if (scl_oe) run_len++;
        else begin
            if (run_len > max_run) max_run = run_len;
            run_len = 0;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic raise_scl();
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b1; wait_n(HALF);
        raise_scl(); wait_n(HALF);
        m_sda = 1'b0; wait_n(HALF);
        m_scl = 1'b0; wait_n(HALF);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; wait_n(HALF);
        raise_scl(); wait_n(HALF);
        m_sda = 1'b1; wait_n(HALF);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wait_n(HALF);
        raise_scl(); wait_n(HALF);
        m_scl = 1'b0; wait_n(4);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wait_n(HALF);
        raise_scl(); wait_n(HALF / 2);
        b = sda_bus; wait_n(HALF / 2);
        m_scl = 1'b0; wait_n(4);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ackb);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(ackb);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(nack);
    endtask

    task automatic host_load(input logic [7:0] d);
        host_data = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    logic [7:0] rd, rd2;
    logic       ak, b1, prev_oe;
    int         n;

    initial begin
        wait_n(5);
        rst_n = 1'b1; enable = 1'b1;
        wait_n(3);
        // R11 reset state
        chk(!scl_oe && !sda_oe && !buf_full && !byte_done && !rw_flag && !timeout_err,
            "R11 reset outputs", {scl_oe, sda_oe, buf_full, byte_done, rw_flag, timeout_err}, 0);
        quiet_exp = 1'b1;

        // Read of two bytes: preloaded first, second supplied during a stretch.
        host_load(8'hA5);
        quiet_exp = 1'b0;
        do_start();
        send_byte({own_addr, 1'b1}, ak);
        chk(ak == 1'b0, "R2 address acknowledged", ak, 0);
        recv_byte(rd, 1'b0);
        chk(rd == 8'hA5, "R4 first byte MSB first", rd, 8'hA5);
        fork
            recv_byte(rd2, 1'b1);
            begin
                wait_n(100);
                chk(scl_oe && !scl_bus, "R6 SCL held while empty", scl_oe, 1);
                host_load(8'h3C);
                prev_oe = sda_oe;
                while (scl_oe) begin
                    prev_oe = sda_oe;
                    @(negedge clk);
                end
                chk(prev_oe == 1'b1, "R7 MSB on SDA before SCL release", prev_oe, 1);
                wait_n(3 * HALF);
                host_load(8'h77);
            end
        join
        chk(rd2 == 8'h3C, "R4 stretched byte", rd2, 8'h3C);
        wait_n(2);
        chk(!sda_oe && !scl_oe, "R5 released after NACK", {scl_oe, sda_oe}, 0);
        chk(!buf_full, "R9 buffer flushed on NACK", buf_full, 0);
        chk(ack_log.size() == 2, "R5 byte_done count", ack_log.size(), 2);
        if (ack_log.size() == 2) begin
            chk(ack_log[0] == 1'b0 && ack_log[1] == 1'b1, "R5 ack status per byte",
                {ack_log[0], ack_log[1]}, 1);
            chk(rw_log[0] && rw_log[1], "R3 direction held over data", {rw_log[0], rw_log[1]}, 3);
        end
        do_stop();
        quiet_exp = 1'b1;

        // Host write outside any transfer must not reach the bus.
        host_load(8'h00);
        wait_n(100);
        chk(buf_full, "R9 idle write accepted", buf_full, 1);

        // Foreign address: nothing driven, buffer kept.
        do_start();
        send_byte({7'h21, 1'b1}, ak);
        chk(ak == 1'b1, "R2 mismatch not acknowledged", ak, 1);
        send_byte(8'h00, ak);
        chk(ak == 1'b1, "R2 ignored until START", ak, 1);
        do_stop();
        chk(buf_full, "R2 buffer untouched by mismatch", buf_full, 1);

        // Auto-fill after the buffered byte runs out.
        fill_en = 1'b1; fill_byte = 8'h35;
        max_run = 0;
        ack_log.delete(); rw_log.delete();
        quiet_exp = 1'b0;
        do_start();
        send_byte({own_addr, 1'b1}, ak);
        recv_byte(rd, 1'b0);
        chk(rd == 8'h00, "R4 stale buffered byte", rd, 8'h00);
        recv_byte(rd, 1'b0);
        chk(rd == 8'hB5, "R8 fill byte MSB forced", rd, 8'hB5);
        recv_byte(rd, 1'b1);
        chk(rd == 8'hB5, "R8 fill repeats", rd, 8'hB5);
        do_stop();
        quiet_exp = 1'b1;
        chk(max_run <= SU + 2, "R8 no long stretch with fill", max_run, SU + 2);
        fill_en = 1'b0;

        // Write direction: address acknowledged, flag cleared, data ignored.
        quiet_exp = 1'b0;
        do_start();
        send_byte({own_addr, 1'b0}, ak);
        chk(ak == 1'b0 && rw_flag == 1'b0, "R3 write direction latched", {ak, rw_flag}, 0);
        send_byte(8'h11, ak);
        chk(ak == 1'b1, "R3 write data not acknowledged", ak, 1);
        do_stop();
        quiet_exp = 1'b1;

        // Stretch timeout.
        stretch_limit = 16'd300;
        quiet_exp = 1'b0;
        do_start();
        send_byte({own_addr, 1'b1}, ak);
        fork
            recv_byte(rd, 1'b1);
            begin
                while (!scl_oe) @(negedge clk);
                n = 0;
                while (scl_oe) begin
                    n++;
                    @(negedge clk);
                end
                quiet_exp = 1'b1;
                chk(n >= 296 && n <= 302, "R10 stretch length", n, 301);
                chk(timeout_err, "R10 error flag", timeout_err, 1);
            end
        join
        chk(rd == 8'hFF, "R10 bus released after timeout", rd, 8'hFF);
        do_stop();

        // Disable while stretching; re-enable must not stretch again.
        stretch_limit = '0;
        quiet_exp = 1'b0;
        do_start();
        send_byte({own_addr, 1'b1}, ak);
        chk(!timeout_err, "R10 flag cleared by START", timeout_err, 0);
        fork
            recv_byte(rd, 1'b1);
            begin
                while (!scl_oe) @(negedge clk);
                wait_n(50);
                chk(scl_oe, "R6 stretch without limit", scl_oe, 1);
                enable = 1'b0;
                wait_n(3);
                chk(!scl_oe && !sda_oe, "R11 disable releases", {scl_oe, sda_oe}, 0);
                enable = 1'b1;
                quiet_exp = 1'b1;
                wait_n(50);
                chk(!scl_oe && !sda_oe, "R11 no stretch after enable", {scl_oe, sda_oe}, 0);
            end
        join
        do_stop();

        // STOP in the middle of a transmitted byte.
        host_load(8'hF0);
        quiet_exp = 1'b0;
        do_start();
        send_byte({own_addr, 1'b1}, ak);
        get_bit(b1);
        chk(b1 == 1'b1, "R4 first bit of F0", b1, 1);
        do_stop();
        wait_n(4);
        chk(!scl_oe && !sda_oe && !buf_full, "R1 STOP mid-byte to start-hunt",
            {scl_oe, sda_oe, buf_full}, 0);
        quiet_exp = 1'b1;
        wait_n(40);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule